// File: doc/BRIEF.md
# Tag-Window Packet Filter for a Shared Broadcast Bus

One copy of this block sits between a shared broadcast bus and the local buffer of a tile group. Every bus beat carries a destination tag and a data word. The filter keeps two programmable tags and a window width. It accepts a beat when at least one of the two stored tags is equal to the beat's tag or lies above it by less than the window width. Accepted beats go to the tile. All other beats are dropped.

The same comparator pair covers three delivery patterns. A width of one with both tags equal gives unicast. A width greater than one gives overlapping multicast windows, so neighbouring groups share one transmission of a feature value. The full width gives broadcast. Configuration writes are accepted at any time. A write only takes hold in a cycle with no bus beat, so a stream of back-to-back beats always sees one consistent setting.

Top module: `tagPairFilter`

## Requirements
- R1: A beat with tag d is accepted when 0 ≤ tagA − d < width. Differences are taken as signed integers.
- R2: A beat is accepted when 0 ≤ tagB − d < width, even if the tagA test fails.
- R3: A beat that fails both tests is dropped. outValid stays 0 in the following cycle and outData keeps the last accepted word.
- R4: A beat whose tag is above a stored tag never matches that tag, whatever the width. For example, tagA=0, width=3 rejects tags 1 and 127; there is no modulo wrap.
- R5: With width=1 and tagA=tagB=i, only tag i is accepted.
- R6: With width=3, tag 0 is accepted by the pairs (0,4), (1,5) and (2,6). The pair (0,4) accepts tags 0, 2 and 3 and rejects tag 1.
- R7: An accepted beat appears on outValid/outData exactly one clock after it was on the bus. outValid is never high without a bus beat one cycle earlier.
- R8: A configuration write in a cycle with busValid=0 applies to beats from the next cycle on.
- R9: A configuration write in a cycle with busValid=1 is held pending. It does not affect that beat or any directly following beats. It takes hold at the end of the first cycle with busValid=0. A later write replaces a pending one.
- R10: After reset outValid=0, outData=0, both tags are 0 and width is 0, so every beat is dropped until a configuration is written.
- R11: width is TAG_W+1 bits wide. width=128 with tagA=127 accepts every 7-bit tag (broadcast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgTagA | input | TAG_W | First stored tag to write |
| cfgTagB | input | TAG_W | Second stored tag to write |
| cfgWidth | input | TAG_W+1 | Window width to write |
| busValid | input | 1 | Bus beat present |
| busTag | input | TAG_W | Destination tag of the beat |
| busData | input | DATA_W | Payload of the beat |
| outValid | output | 1 | Accepted beat present for the tile |
| outData | output | DATA_W | Payload of the last accepted beat |

## Verification
The bench aims at the window edges. It checks a difference of exactly width−1, which must pass, and exactly width, which must fail. It also checks beat tags above a stored tag. A comparator working in unsigned 7-bit arithmetic would wrap these and accept tag 127 against tag 0. It drives configuration writes in the same cycle as a beat and in the middle of back-to-back beats. A design that applies writes at once would switch filtering in the middle of a stream, and one that drops the pending write would never switch at all. Broadcast at full width catches a width field that is one bit too narrow. Dropped beats are checked to leave outData unchanged.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic stagePend;   // park incoming config in the pending register
    logic commitCfg;   // move a config into the active register
    logic fromPort;    // commit takes the port values instead of the pending ones
    logic capture;     // a bus beat is present this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/tpfControl.sv
module tpfControl
  import tpf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         busValid,
  output ctrlStrobes_t strobes
);
  logic pendValid;
  logic commitNow;

  // Config changes only land in a bus-idle cycle, so every beat sees one setting.
  assign commitNow = (cfgWrEn | pendValid) & ~busValid;

  always_comb begin
    strobes.stagePend = cfgWrEn & busValid;
    strobes.commitCfg = commitNow;
    strobes.fromPort  = cfgWrEn;
    strobes.capture   = busValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pendValid <= 1'b0;
    else if (commitNow)      pendValid <= 1'b0;
    else if (cfgWrEn)        pendValid <= 1'b1;
  end

  // R9: a pending write survives every cycle that carries a beat
  assert_pend_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && busValid) |=> pendValid);
  // R9: a pending write is committed by the first idle cycle
  assert_pend_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !busValid) |=> !pendValid);
endmodule

// File: rtl/tpfWindowMatch.sv
module tpfWindowMatch #(
  parameter int TAG_W = 7
) (
  input  logic [TAG_W-1:0] storedTag,
  input  logic [TAG_W-1:0] beatTag,
  input  logic [TAG_W:0]   width,
  output logic             hit
);
  logic [TAG_W:0] diff;

  // One extra bit: its top bit set means the signed difference is negative.
  assign diff = {1'b0, storedTag} - {1'b0, beatTag};
  assign hit  = ~diff[TAG_W] & (diff < width);
endmodule

// File: rtl/tpfDatapath.sv
module tpfDatapath
  import tpf_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [TAG_W-1:0]  cfgTagA,
  input  logic [TAG_W-1:0]  cfgTagB,
  input  logic [TAG_W:0]    cfgWidth,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam int NUM_TAGS = 2;

  logic [TAG_W-1:0] pendTag [NUM_TAGS];
  logic [TAG_W-1:0] actTag  [NUM_TAGS];
  logic [TAG_W-1:0] portTag [NUM_TAGS];
  logic [TAG_W:0]   pendWidth, actWidth;
  logic [NUM_TAGS-1:0] hits;
  logic accept;

  assign portTag[0] = cfgTagA;
  assign portTag[1] = cfgTagB;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : gTag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendTag[g] <= '0;
        actTag[g]  <= '0;
      end else begin
        if (strobes.stagePend) pendTag[g] <= portTag[g];
        if (strobes.commitCfg)
          actTag[g] <= strobes.fromPort ? portTag[g] : pendTag[g];
      end
    end

    tpfWindowMatch #(.TAG_W(TAG_W)) uMatch (
      .storedTag (actTag[g]),
      .beatTag   (busTag),
      .width     (actWidth),
      .hit       (hits[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWidth <= '0;
      actWidth  <= '0;
    end else begin
      if (strobes.stagePend) pendWidth <= cfgWidth;
      if (strobes.commitCfg) actWidth <= strobes.fromPort ? cfgWidth : pendWidth;
    end
  end

  assign accept = strobes.capture & (|hits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= accept;
      if (accept) outData <= busData;
    end
  end

  // R7: no output without a bus beat one cycle before
  assert_out_needs_beat_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobes.capture));
  // R7: forwarded word is the bus word of the previous cycle
  assert_out_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData == $past(busData)));
  // R3: a drop leaves the output word untouched
  assert_drop_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));
  // R9: active setting never changes across a cycle that carried a beat
  assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> $stable(actWidth));
  // R10: width zero never admits a beat
  assert_zero_width_R10: assert property (@(posedge clk) disable iff (!rstN)
    (actWidth == '0) |=> !outValid);
endmodule

// File: rtl/tagPairFilter.sv
module tagPairFilter
  import tpf_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [TAG_W-1:0]  cfgTagA,
  input  logic [TAG_W-1:0]  cfgTagB,
  input  logic [TAG_W:0]    cfgWidth,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  ctrlStrobes_t strobes;

  tpfControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .busValid (busValid),
    .strobes  (strobes)
  );

  tpfDatapath #(.TAG_W(TAG_W), .DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgTagA  (cfgTagA),
    .cfgTagB  (cfgTagB),
    .cfgWidth (cfgWidth),
    .busTag   (busTag),
    .busData  (busData),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: tb/tagPairFilter_test.sv
`timescale 1ns/1ps
module tagPairFilter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgTagA = '0, cfgTagB = '0;
  logic [7:0]  cfgWidth = '0;
  logic        busValid = 1'b0;
  logic [6:0]  busTag = '0;
  logic [31:0] busData = '0;
  logic        outValid;
  logic [31:0] outData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state, kept from the requirements
  int mA = 0, mB = 0, mW = 0, pA = 0, pB = 0, pW = 0;
  bit mPend = 0;
  logic [31:0] expData = '0;

  always #2.5 clk = ~clk;

  tagPairFilter uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTagA(cfgTagA), .cfgTagB(cfgTagB),
    .cfgWidth(cfgWidth), .busValid(busValid), .busTag(busTag), .busData(busData),
    .outValid(outValid), .outData(outData)
  );

  function automatic bit inWin(int t, int d, int w);
    return (t - d >= 0) && (t - d < w);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check the registered result after the next posedge.
  task automatic step(bit v, int t, logic [31:0] d, bit wr, int a, int b, int w, string req);
    bit expV;
    busValid = v; busTag = t[6:0]; busData = d;
    cfgWrEn = wr; cfgTagA = a[6:0]; cfgTagB = b[6:0]; cfgWidth = w[7:0];
    expV = v && (inWin(mA, t, mW) || inWin(mB, t, mW));
    if (expV) expData = d;
    if ((wr || mPend) && !v) begin
      if (wr) begin mA = a; mB = b; mW = w; end
      else begin mA = pA; mB = pB; mW = pW; end
      mPend = 0;
    end else if (wr) begin
      pA = a; pB = b; pW = w; mPend = 1;
    end
    @(posedge clk); #1;
    chk(req, "outValid", {31'b0, outValid}, {31'b0, expV});
    chk(req, "outData", outData, expData);
    @(negedge clk);
    busValid = 0; cfgWrEn = 0;
  endtask

  task automatic cfg(int a, int b, int w, string req);
    step(0, 0, 0, 1, a, b, w, req);
  endtask

  task automatic beat(int t, logic [31:0] d, string req);
    step(1, t, d, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #12 rstN = 1'b1;
    @(negedge clk);
    // R10: reset state and drop-all before configuration
    chk("R10", "outValid", {31'b0, outValid}, 32'd0);
    chk("R10", "outData", outData, 32'd0);
    beat(0, 32'h1111, "R10");
    // R8, R5: idle-cycle write, unicast tag 3
    cfg(3, 3, 1, "R8");
    beat(3, 32'hA003, "R5");
    beat(2, 32'hA002, "R5");
    beat(4, 32'hA004, "R3");
    // R6: pair (0,4) with width 3
    cfg(0, 4, 3, "R6");
    beat(0, 32'hB000, "R6");
    beat(1, 32'hB001, "R6");
    beat(2, 32'hB002, "R6");
    beat(3, 32'hB003, "R6");
    beat(4, 32'hB004, "R6");
    beat(5, 32'hB005, "R6");
    cfg(1, 5, 3, "R6");  beat(0, 32'hB100, "R6");
    cfg(2, 6, 3, "R6");  beat(0, 32'hB200, "R6");
    cfg(3, 7, 3, "R6");  beat(0, 32'hB300, "R6");
    // R4: no wrap above a stored tag
    cfg(0, 0, 3, "R4");
    beat(127, 32'hC07F, "R4");
    beat(1, 32'hC001, "R4");
    beat(126, 32'hC07E, "R4");
    // R1/R2: width edges and single-tag hits
    cfg(50, 20, 2, "R1");
    beat(49, 32'hD031, "R1");
    beat(48, 32'hD030, "R1");
    beat(19, 32'hD013, "R2");
    beat(18, 32'hD012, "R2");
    beat(21, 32'hD015, "R2");
    // R11: broadcast at full width
    cfg(127, 127, 128, "R11");
    beat(0, 32'hE000, "R11");
    beat(64, 32'hE040, "R11");
    beat(127, 32'hE07F, "R11");
    // R9: write during a stream of beats
    cfg(3, 3, 1, "R9");
    step(1, 3, 32'hF001, 1, 9, 9, 1, "R9");
    beat(3, 32'hF002, "R9");
    step(1, 9, 32'hF003, 1, 11, 11, 1, "R9");
    beat(9, 32'hF004, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    beat(9, 32'hF005, "R9");
    beat(11, 32'hF006, "R9");
    // R7: idle cycle gives no output
    step(0, 11, 32'hF007, 0, 0, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit wr = ($urandom % 12) == 0;
      int w = (($urandom % 8) == 0) ? 128 : int'($urandom % 9);
      int t = (($urandom % 2) == 0) ? int'($urandom % 128) : ((mA - int'($urandom % 10)) & 127);
      step(v, t, $urandom, wr, int'($urandom % 128), int'($urandom % 128), w, "R1 R2 R3 R9");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule